// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits between an SDRAM command scheduler and the memory command bus. It decides when the memory goes into a power-saving state and when it comes back out. It supports three states: power-down, self-refresh per chip select, and deep power-down for LPDDR2-class memory. Power-down starts in one of two ways. Either software raises a level request, or the controller stays idle for a programmable number of cycles. Before any entry command, the block closes every open bank with a precharge-all command. It tracks the open banks from the commands that the scheduler hands over.

While a low-power state is active, the block holds off the scheduler by dropping `cmd_ready`. A pending access wakes the memory from power-down without software action. Self-refresh and deep power-down end when software withdraws its request. Every exit except deep power-down passes through a programmable exit-latency wait before `cmd_ready` returns. Deep power-down loses the device state, so its exit parks the block with a re-initialisation flag raised. The block stays there until the init sequencer reports completion.

Top module: `sdlp_seq`

## Requirements
- R1: After synchronous reset: `lp_state`=0 (idle), `mem_cmd`=0 (no-op), `mem_cs` all ones, `cmd_ready`=1, and `sr_ack`, `reinit_req` and `dpd_err` all 0.
- R2: A non-zero `cfg_idle_limit` of L starts an automatic power-down on the (L+1)-th consecutive cycle that is spent in idle with `cmd_valid` low. Any cycle with `cmd_valid` high restarts the count. A limit of 0 never starts an automatic entry.
- R3: Entry is decided only in idle and only in a cycle with `cmd_valid` low. Priority, from highest: deep power-down (`sw_dpd_req` with `cfg_lpddr2`=1), then self-refresh (`sw_sr_req` with a non-zero `sw_sr_mask`), then a software power-down (`sw_pd_req`), then the idle trigger.
- R4: If any bank is open at the entry decision, the next cycle shows precharge-all (`mem_cmd`=1, all chip selects), `lp_state`=1, and the entry command follows `cfg_pre_wait`+1 cycles later. If no bank is open, the entry command appears in the cycle right after the decision.
- R5: Bank tracking changes only on an accepted command (`cmd_valid` and `cmd_ready`), selected by `cmd_op`: 1 opens bank `cmd_bank` of chip select `cmd_cs`; 2 closes that bank; 3 closes every bank of `cmd_cs`; 0 (read/write) changes nothing. The block's own precharge-all closes all banks.
- R6: Power-down entry shows `mem_cmd`=2 and `lp_state`=2. In that state, `cmd_valid` high produces `mem_cmd`=3 (exit) in the next cycle.
- R7: Self-refresh entry shows `mem_cmd`=4 with `mem_cs` equal to the mask captured at the decision, `lp_state`=3, and `sr_ack` equal to that mask. When `sw_sr_req` falls, `mem_cmd`=5 appears with the same `mem_cs`, and `sr_ack` returns to 0.
- R8: After a power-down or self-refresh exit command, `lp_state`=5 and `cmd_ready`=0. Idle and `cmd_ready`=1 return `cfg_exit_wait`+1 cycles after the exit command.
- R9: Deep power-down entry shows `mem_cmd`=6 and `lp_state`=4. When `sw_dpd_req` falls, the block shows `mem_cmd`=7, `lp_state`=6 and `reinit_req`=1, and keeps `cmd_ready` low. `init_done` high returns it to idle on the next cycle.
- R10: `sw_dpd_req` with `cfg_lpddr2`=0 causes no entry and raises `dpd_err` in the following cycle. Lower-priority requests proceed as usual.
- R11: `cmd_ready` is 1 only in idle. `mem_cmd` is 0 in every cycle that does not carry one of the commands above. `mem_cs` is all ones except with codes 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idle_limit | input | IDLE_W | Idle cycles before automatic power-down, 0 disables |
| cfg_pre_wait | input | WAIT_W | Extra cycles between precharge-all and entry |
| cfg_exit_wait | input | WAIT_W | Extra cycles of exit latency |
| cfg_lpddr2 | input | 1 | Memory supports deep power-down |
| sw_pd_req | input | 1 | Software power-down request (level) |
| sw_sr_req | input | 1 | Software self-refresh request (level) |
| sw_sr_mask | input | NCS | Chip selects to place in self-refresh |
| sw_dpd_req | input | 1 | Software deep power-down request (level) |
| init_done | input | 1 | Re-initialisation finished |
| cmd_valid | input | 1 | Scheduler has a command pending |
| cmd_op | input | 2 | Command class: 0 rd/wr, 1 activate, 2 precharge, 3 precharge all |
| cmd_cs | input | CSW | Chip select of the command |
| cmd_bank | input | BKW | Bank of the command |
| cmd_ready | output | 1 | Scheduler may issue |
| mem_cmd | output | 3 | Low-power command code |
| mem_cs | output | NCS | Chip selects addressed by `mem_cmd` |
| lp_state | output | 3 | Current state code |
| sr_ack | output | NCS | Chip selects now in self-refresh |
| reinit_req | output | 1 | Re-initialisation needed after deep power-down |
| dpd_err | output | 1 | Deep power-down requested on unsupported memory |

## Verification
The bench builds the block with two chip selects, four banks, a 6-bit idle threshold and 4-bit wait counters. The small thresholds and waits (5, 3 and 2 cycles) make idle-triggered entry, the precharge delay and the exit latency short enough to exercise several times. They are also short enough to run the limit-zero case for many cycles. `cfg_lpddr2` is toggled at run time, so one build covers both the rejected and the accepted deep power-down paths.

// File: rtl/sdlp_pkg.sv
package sdlp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_PREWAIT = 3'd1, ST_PD = 3'd2, ST_SR = 3'd3,
    ST_DPD = 3'd4, ST_EXIT = 3'd5, ST_REINIT = 3'd6
  } lp_state_e;

  typedef enum logic [2:0] {
    MC_NOP = 3'd0, MC_PREA = 3'd1, MC_PDE = 3'd2, MC_PDX = 3'd3,
    MC_SRE = 3'd4, MC_SRX = 3'd5, MC_DPDE = 3'd6, MC_DPDX = 3'd7
  } mem_cmd_e;

  typedef enum logic [1:0] {
    OP_RDWR = 2'd0, OP_ACT = 2'd1, OP_PRE = 2'd2, OP_PREALL = 2'd3
  } cmd_op_e;

  function automatic mem_cmd_e entry_cmd(lp_state_e t);
    case (t)
      ST_SR:   return MC_SRE;
      ST_DPD:  return MC_DPDE;
      default: return MC_PDE;
    endcase
  endfunction
endpackage

// File: rtl/sdlp_idle_cnt.sv
module sdlp_idle_cnt #(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [IDLE_W-1:0] limit,
  output logic              hit
);
  localparam logic [IDLE_W-1:0] CMAX = '1;
  logic [IDLE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt != CMAX) cnt <= cnt + 1'b1;
  end

  assign hit = en && (limit != '0) && (cnt >= limit);

  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));
endmodule

// File: rtl/sdlp_bank_map.sv
module sdlp_bank_map #(
  parameter int NCS = 2,
  parameter int NBANK = 8,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int BKW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           accept,
  input  logic [1:0]     op,
  input  logic [CSW-1:0] cs,
  input  logic [BKW-1:0] bank,
  input  logic           clr_all,
  output logic           any_open
);
  import sdlp_pkg::*;
  logic [NCS-1:0][NBANK-1:0] open_q;

  for (genvar c = 0; c < NCS; c++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst || clr_all) open_q[c] <= '0;
      else if (accept && cs == CSW'(c)) begin
        case (cmd_op_e'(op))
          OP_ACT:    open_q[c][bank] <= 1'b1;
          OP_PRE:    open_q[c][bank] <= 1'b0;
          OP_PREALL: open_q[c] <= '0;
          default:   ;
        endcase
      end
    end
  end

  assign any_open = |open_q;

  p_prea_clears_r5: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> !any_open);
endmodule

// File: rtl/sdlp_down_timer.sv
module sdlp_down_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              zero
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/sdlp_seq.sv
module sdlp_seq #(
  parameter int NCS = 2,
  parameter int NBANK = 8,
  parameter int IDLE_W = 16,
  parameter int WAIT_W = 8,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int BKW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDLE_W-1:0] cfg_idle_limit,
  input  logic [WAIT_W-1:0] cfg_pre_wait,
  input  logic [WAIT_W-1:0] cfg_exit_wait,
  input  logic              cfg_lpddr2,
  input  logic              sw_pd_req,
  input  logic              sw_sr_req,
  input  logic [NCS-1:0]    sw_sr_mask,
  input  logic              sw_dpd_req,
  input  logic              init_done,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [CSW-1:0]    cmd_cs,
  input  logic [BKW-1:0]    cmd_bank,
  output logic              cmd_ready,
  output logic [2:0]        mem_cmd,
  output logic [NCS-1:0]    mem_cs,
  output logic [2:0]        lp_state,
  output logic [NCS-1:0]    sr_ack,
  output logic              reinit_req,
  output logic              dpd_err
);
  import sdlp_pkg::*;

  lp_state_e st, nxt, tgt, ntgt, want;
  mem_cmd_e  ncmd;
  logic [NCS-1:0] srm, nsrm, ncs;
  logic idle_hit, any_open, tmr_zero, tload, clr_all, go;
  logic [WAIT_W-1:0] tval;

  sdlp_idle_cnt #(.IDLE_W(IDLE_W)) u_idle (
    .clk(clk), .rst(rst), .en(st == ST_IDLE && !cmd_valid),
    .limit(cfg_idle_limit), .hit(idle_hit));

  sdlp_bank_map #(.NCS(NCS), .NBANK(NBANK)) u_banks (
    .clk(clk), .rst(rst), .accept(cmd_valid && cmd_ready), .op(cmd_op),
    .cs(cmd_cs), .bank(cmd_bank), .clr_all(clr_all), .any_open(any_open));

  sdlp_down_timer #(.WAIT_W(WAIT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tload), .load_val(tval), .zero(tmr_zero));

  // Request arbitration: deep power-down, self-refresh, software PD, idle.
  always_comb begin
    go = 1'b1;
    want = ST_PD;
    if (sw_dpd_req && cfg_lpddr2)          want = ST_DPD;
    else if (sw_sr_req && |sw_sr_mask)     want = ST_SR;
    else if (sw_pd_req || idle_hit)        want = ST_PD;
    else                                   go = 1'b0;
  end

  always_comb begin
    nxt = st; ntgt = tgt; nsrm = srm;
    ncmd = MC_NOP; ncs = '1;
    tload = 1'b0; tval = cfg_exit_wait; clr_all = 1'b0;
    case (st)
      ST_IDLE: if (!cmd_valid && go) begin
        ntgt = want;
        if (want == ST_SR) nsrm = sw_sr_mask;
        if (any_open) begin
          nxt = ST_PREWAIT; ncmd = MC_PREA; clr_all = 1'b1;
          tload = 1'b1; tval = cfg_pre_wait;
        end else begin
          nxt = want; ncmd = entry_cmd(want);
          if (want == ST_SR) ncs = sw_sr_mask;
        end
      end
      ST_PREWAIT: if (tmr_zero) begin
        nxt = tgt; ncmd = entry_cmd(tgt);
        if (tgt == ST_SR) ncs = srm;
      end
      ST_PD: if (cmd_valid) begin
        nxt = ST_EXIT; ncmd = MC_PDX; tload = 1'b1;
      end
      ST_SR: if (!sw_sr_req) begin
        nxt = ST_EXIT; ncmd = MC_SRX; ncs = srm; tload = 1'b1;
      end
      ST_DPD: if (!sw_dpd_req) begin
        nxt = ST_REINIT; ncmd = MC_DPDX;
      end
      ST_EXIT:   if (tmr_zero) nxt = ST_IDLE;
      ST_REINIT: if (init_done) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; tgt <= ST_PD; srm <= '0;
      mem_cmd <= MC_NOP; mem_cs <= '1; cmd_ready <= 1'b1;
      sr_ack <= '0; reinit_req <= 1'b0; dpd_err <= 1'b0;
    end else begin
      st <= nxt; tgt <= ntgt; srm <= nsrm;
      mem_cmd <= ncmd; mem_cs <= ncs;
      cmd_ready <= (nxt == ST_IDLE);
      sr_ack <= (nxt == ST_SR) ? nsrm : '0;
      reinit_req <= (nxt == ST_REINIT);
      dpd_err <= sw_dpd_req && !cfg_lpddr2;
    end
  end

  assign lp_state = st;

  p_closed_on_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd == MC_PDE || mem_cmd == MC_SRE || mem_cmd == MC_DPDE) |-> !any_open);
  p_dpd_needs_lpddr2_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !cmd_valid && sw_dpd_req && !cfg_lpddr2) |=> (mem_cmd != MC_DPDE));
  p_ack_in_sr_r7: assert property (@(posedge clk) disable iff (rst)
    (|sr_ack) |-> (st == ST_SR));
  p_reinit_after_dpdx_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(reinit_req) |-> (mem_cmd == MC_DPDX));
  p_pd_wake_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PD && cmd_valid) |=> (mem_cmd == MC_PDX));
  p_ready_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXIT && !tmr_zero) |=> !cmd_ready);
endmodule

// File: tb/sdlp_seq_tb_top.sv
module sdlp_seq_tb_top;
  localparam int NCS = 2, NBANK = 4, IDLE_W = 6, WAIT_W = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [IDLE_W-1:0] cfg_idle_limit = '0;
  logic [WAIT_W-1:0] cfg_pre_wait = 4'd3, cfg_exit_wait = 4'd2;
  logic cfg_lpddr2 = 1'b0, sw_pd_req = 1'b0, sw_sr_req = 1'b0, sw_dpd_req = 1'b0;
  logic init_done = 1'b0, cmd_valid = 1'b0;
  logic [NCS-1:0] sw_sr_mask = '0;
  logic [1:0] cmd_op = '0;
  logic cmd_cs = 1'b0;
  logic [1:0] cmd_bank = '0;
  logic cmd_ready, reinit_req, dpd_err;
  logic [2:0] mem_cmd, lp_state;
  logic [NCS-1:0] mem_cs, sr_ack;

  always #4 clk = ~clk;

  sdlp_seq #(.NCS(NCS), .NBANK(NBANK), .IDLE_W(IDLE_W), .WAIT_W(WAIT_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_idle_limit(cfg_idle_limit), .cfg_pre_wait(cfg_pre_wait),
    .cfg_exit_wait(cfg_exit_wait), .cfg_lpddr2(cfg_lpddr2), .sw_pd_req(sw_pd_req),
    .sw_sr_req(sw_sr_req), .sw_sr_mask(sw_sr_mask), .sw_dpd_req(sw_dpd_req),
    .init_done(init_done), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_cs(cmd_cs),
    .cmd_bank(cmd_bank), .cmd_ready(cmd_ready), .mem_cmd(mem_cmd), .mem_cs(mem_cs),
    .lp_state(lp_state), .sr_ack(sr_ack), .reinit_req(reinit_req), .dpd_err(dpd_err));

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit started = 0, done = 0;

  // Behavioural reference model; states/commands as integer codes from the brief.
  int m_st = 0, m_cmd = 0, m_cs = 3, m_rdy = 1, m_ack = 0, m_re = 0, m_err = 0;
  int run = 0, wcnt = 0, target = 2, smask = 0;
  bit open_b[2][4];

  function automatic int entry_code(int t);
    return (t == 3) ? 4 : (t == 4) ? 6 : 2;
  endfunction

  function automatic bit any_bank();
    bit a = 0;
    for (int c = 0; c < 2; c++) for (int b = 0; b < 4; b++) a |= open_b[c][b];
    return a;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_st = 0; m_cmd = 0; m_cs = 3; m_rdy = 1; m_ack = 0; m_re = 0; m_err = 0;
      run = 0; wcnt = 0; smask = 0;
      for (int c = 0; c < 2; c++) for (int b = 0; b < 4; b++) open_b[c][b] = 0;
    end else begin
      int ns, w;
      bit hit, want_go;
      ns = m_st; m_cmd = 0; m_cs = 3;
      if (cmd_valid && m_rdy == 1) begin
        if (cmd_op == 1) open_b[cmd_cs][cmd_bank] = 1;
        else if (cmd_op == 2) open_b[cmd_cs][cmd_bank] = 0;
        else if (cmd_op == 3) for (int b = 0; b < 4; b++) open_b[cmd_cs][b] = 0;
      end
      hit = (m_st == 0) && !cmd_valid && cfg_idle_limit != 0 && run >= int'(cfg_idle_limit);
      run = (m_st == 0 && !cmd_valid) ? ((run < 63) ? run + 1 : 63) : 0;
      case (m_st)
        0: if (!cmd_valid) begin
          want_go = 1;
          if (sw_dpd_req && cfg_lpddr2) w = 4;
          else if (sw_sr_req && sw_sr_mask != 0) w = 3;
          else if (sw_pd_req || hit) w = 2;
          else begin want_go = 0; w = 0; end
          if (want_go) begin
            target = w;
            if (w == 3) smask = int'(sw_sr_mask);
            if (any_bank()) begin
              for (int c = 0; c < 2; c++) for (int b = 0; b < 4; b++) open_b[c][b] = 0;
              ns = 1; m_cmd = 1; wcnt = int'(cfg_pre_wait);
            end else begin
              ns = w; m_cmd = entry_code(w); if (w == 3) m_cs = smask;
            end
          end
        end
        1: if (wcnt == 0) begin
          ns = target; m_cmd = entry_code(target); if (target == 3) m_cs = smask;
        end else wcnt--;
        2: if (cmd_valid) begin ns = 5; m_cmd = 3; wcnt = int'(cfg_exit_wait); end
        3: if (!sw_sr_req) begin ns = 5; m_cmd = 5; m_cs = smask; wcnt = int'(cfg_exit_wait); end
        4: if (!sw_dpd_req) begin ns = 6; m_cmd = 7; end
        5: if (wcnt == 0) ns = 0; else wcnt--;
        6: if (init_done) ns = 0;
        default: ns = 0;
      endcase
      m_st = ns;
      m_rdy = (ns == 0); m_ack = (ns == 3) ? smask : 0; m_re = (ns == 6);
      m_err = sw_dpd_req && !cfg_lpddr2;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    cycles++;
    chk("R3/R4/R6/R7/R9 lp_state", int'(lp_state), m_st);
    chk("R4/R6/R7/R9/R11 mem_cmd", int'(mem_cmd), m_cmd);
    chk("R7/R11 mem_cs", int'(mem_cs), m_cs);
    chk("R8/R11 cmd_ready", int'(cmd_ready), m_rdy);
    chk("R7 sr_ack", int'(sr_ack), m_ack);
    chk("R9 reinit_req", int'(reinit_req), m_re);
    chk("R10 dpd_err", int'(dpd_err), m_err);
    if (cycles > 5000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 5000 cycles", cycles);
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic issue(int op, int cs, int bank);
    cmd_valid = 1; cmd_op = 2'(op); cmd_cs = 1'(cs); cmd_bank = 2'(bank);
    step(1);
    cmd_valid = 0; cmd_op = 0;
  endtask

  initial begin
    step(3);
    rst = 0;
    // R1: reset state at the ports
    @(negedge clk);
    chk("R1 state", int'(lp_state), 0);
    chk("R1 cmd", int'(mem_cmd), 0);
    chk("R1 ready", int'(cmd_ready), 1);
    chk("R1 cs", int'(mem_cs), 3);
    step(1);
    // R5: open banks on both chip selects, then idle-triggered entry (R2, R4)
    issue(1, 0, 1); issue(1, 1, 3); issue(0, 1, 3);
    cfg_idle_limit = 6'd5;
    step(20);
    // R6/R8: access wakes power-down; exit latency before ready
    cmd_valid = 1; cmd_op = 0;
    step(8);
    cmd_valid = 0;
    cfg_idle_limit = 6'd0;
    // R2: limit zero never enters
    step(25);
    chk("R2 no entry with limit 0", int'(lp_state), 0);
    // R5: activate then close; software PD enters directly without precharge (R4)
    issue(1, 0, 2); issue(2, 0, 2);
    issue(1, 1, 0); issue(3, 1, 0);
    sw_pd_req = 1;
    step(4);
    sw_pd_req = 0;
    cmd_valid = 1; step(6); cmd_valid = 0;
    // R3: held command blocks a software request
    cmd_valid = 1; sw_pd_req = 1;
    step(6);
    chk("R3 held command blocks entry", int'(lp_state), 0);
    cmd_valid = 0; step(3); sw_pd_req = 0;
    cmd_valid = 1; step(6); cmd_valid = 0;
    // R3/R7: self-refresh outranks power-down, open bank forces precharge first
    issue(1, 1, 1);
    sw_sr_mask = 2'b10; sw_sr_req = 1; sw_pd_req = 1;
    step(10);
    chk("R7 sr_ack mask", int'(sr_ack), 2);
    sw_pd_req = 0; sw_sr_req = 0;
    step(6);
    // R3: zero mask is ignored
    sw_sr_mask = 2'b00; sw_sr_req = 1;
    step(5);
    chk("R3 zero mask ignored", int'(lp_state), 0);
    sw_sr_req = 0;
    // R10: deep power-down refused without LPDDR2
    sw_dpd_req = 1;
    step(4);
    chk("R10 dpd refused", int'(lp_state), 0);
    chk("R10 dpd_err raised", int'(dpd_err), 1);
    // R9: accepted with LPDDR2, exit needs init_done
    cfg_lpddr2 = 1;
    step(5);
    sw_dpd_req = 0;
    step(5);
    chk("R9 waits for init", int'(reinit_req), 1);
    init_done = 1; step(1); init_done = 0;
    step(4);
    // R3: deep power-down outranks self-refresh
    sw_sr_mask = 2'b01; sw_sr_req = 1; sw_dpd_req = 1;
    step(4);
    sw_dpd_req = 0; sw_sr_req = 0; step(3);
    init_done = 1; step(1); init_done = 0;
    step(5);
    finish_run();
  end
endmodule